// File: doc/BRIEF.md
# Min-Sum Check Node Cell

This cell carries out the check-node half of a normalized min-sum LDPC decoder for one parity row. The edge messages of the row arrive one per cycle in sign-magnitude form. For each edge the cell keeps only a compact summary: the smallest magnitude, the runner-up magnitude, the edge position of the smallest, one stored sign bit per edge, and the XOR of all signs seen so far.

When the edge flagged as last is accepted, the summary is copied into a result bank. The collector then starts a new row straight away. Any edge of the finished row can then be read back by index. The returned magnitude is the runner-up for the edge that held the minimum and the minimum for every other edge, scaled by 0.75. The returned sign is the product of all the other edges' signs.

A two-state machine controls the collector. ST_IDLE means no edge of the current row has been taken yet, and the next edge starts from a fresh summary. ST_COLLECT means a row is open. The transitions are:
- ST_IDLE to ST_COLLECT on an accepted edge that is not last.
- ST_COLLECT to ST_IDLE on an accepted last edge.
- ST_IDLE stays in ST_IDLE on an accepted last edge.
- Cycles without an accepted edge hold the state.

Top module: `mscn_cell`

## Requirements
- R1: After reset `row_ready` and `out_valid` are 0.
- R2: A message is 6 bits. Bit 5 is the sign (1 = negative) and bits 4:0 are the magnitude. Input and output use the same layout.
- R3: The output magnitude for edge e is based on the second-smallest magnitude of the row if e held the smallest, and on the smallest otherwise. Each row starts with both values at 31.
- R4: The edge position of an edge is its order of arrival within the row, starting at 0. Among equal smallest magnitudes, the earliest edge keeps the minimum position.
- R5: The output sign for edge e is the XOR of the signs of all the other edges in the row.
- R6: The output magnitude equals m - (m >> 2), truncated, where m is the magnitude chosen by R3. It therefore never exceeds 24.
- R7: Accepting an edge with `in_last` high makes that row's results readable and sets `row_ready`, which stays set. The results do not change while the next row is being collected.
- R8: Cycles with `in_valid` low are ignored, whatever `in_msg` and `in_last` carry.
- R9: A read with `rd_en` high returns `out_valid` and `out_msg` one cycle later. `out_valid` is raised only when `rd_en` was high and `row_ready` was set.
- R10: A new row carries nothing over from the previous row's magnitudes or signs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Edge message present |
| in_msg | input | 6 | Sign-magnitude edge message |
| in_last | input | 1 | Final edge of the row |
| rd_en | input | 1 | Read request |
| rd_idx | input | 5 | Edge position to read |
| row_ready | output | 1 | A completed row is readable |
| out_valid | output | 1 | Read response valid |
| out_msg | output | 6 | Outgoing edge message |

## Verification
The rows are chosen so that each one exposes a different fault:
- A short mixed-sign row shows whether min and runner-up are swapped and whether an edge's own sign is excluded.
- A row of all 31 magnitudes hits the top of the scaling range and the reset value of the sort.
- A full 24-edge row with falling magnitudes puts the minimum at the last position.
- A row of zero magnitudes with negative signs tests zero handling.
- A row driven with idle cycles that carry junk and a stray last flag shows whether invalid cycles leak in.
- A row that is read back while the next row is half collected, followed by a row of larger magnitudes, shows whether results are held and whether state leaks from one row to the next.

// File: rtl/mscn_pkg.sv
package mscn_pkg;
    parameter int MAG_W     = 5;
    parameter int MAX_EDGES = 24;
    localparam int MSG_W    = MAG_W + 1;
    localparam int IDX_W    = $clog2(MAX_EDGES);
    localparam logic [MAG_W-1:0] MAG_MAX = {MAG_W{1'b1}};

    typedef enum logic {
        ST_IDLE,
        ST_COLLECT
    } cn_state_e;

    typedef struct packed {
        logic [MAG_W-1:0] min1;
        logic [MAG_W-1:0] min2;
        logic [IDX_W-1:0] pos;
    } minpair_t;
endpackage

// File: rtl/mscn_sort_step.sv
module mscn_sort_step
    import mscn_pkg::*;
(
    input  minpair_t             cur,
    input  logic [MAG_W-1:0]     mag,
    input  logic [IDX_W-1:0]     pos,
    output minpair_t             nxt
);
    always_comb begin
        nxt = cur;
        if (mag < cur.min1) begin
            nxt.min2 = cur.min1;
            nxt.min1 = mag;
            nxt.pos  = pos;
        end else if (mag < cur.min2) begin
            nxt.min2 = mag;
        end
    end
endmodule

// File: rtl/mscn_norm.sv
module mscn_norm #(
    parameter int W = 5
) (
    input  logic [W-1:0] m_in,
    output logic [W-1:0] m_out
);
    assign m_out = m_in - (m_in >> 2);
endmodule

// File: rtl/mscn_edge_out.sv
module mscn_edge_out
    import mscn_pkg::*;
(
    input  minpair_t               res,
    input  logic                   res_prod,
    input  logic [MAX_EDGES-1:0]   res_sgn,
    input  logic [IDX_W-1:0]       sel_idx,
    output logic [MSG_W-1:0]       msg
);
    logic [MAG_W-1:0] mag_pick;
    logic [MAG_W-1:0] mag_scaled;
    logic             own_sgn;

    always_comb begin
        own_sgn = 1'b0;
        for (int e = 0; e < MAX_EDGES; e++) begin
            if (sel_idx == IDX_W'(e)) own_sgn = res_sgn[e];
        end
        mag_pick = (sel_idx == res.pos) ? res.min2 : res.min1;
    end

    mscn_norm #(.W(MAG_W)) u_norm (
        .m_in  (mag_pick),
        .m_out (mag_scaled)
    );

    assign msg = {res_prod ^ own_sgn, mag_scaled};
endmodule

// File: rtl/mscn_cell.sv
module mscn_cell
    import mscn_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [5:0]       in_msg,
    input  logic             in_last,
    input  logic             rd_en,
    input  logic [4:0]       rd_idx,
    output logic             row_ready,
    output logic             out_valid,
    output logic [5:0]       out_msg
);
    localparam minpair_t SORT_INIT = '{min1: MAG_MAX, min2: MAG_MAX, pos: '0};

    cn_state_e            state, state_nxt;
    logic [IDX_W-1:0]     cnt;
    minpair_t             acc, base, step_nxt, res;
    logic                 acc_prod, base_prod, res_prod;
    logic [MAX_EDGES-1:0] acc_sgn, sgn_nxt, res_sgn;
    logic [IDX_W-1:0]     edge_pos;
    logic [MSG_W-1:0]     rd_msg;
    logic                 in_sign;

    assign in_sign   = in_msg[MAG_W];
    assign edge_pos  = (state == ST_IDLE) ? '0 : cnt;
    assign base      = (state == ST_IDLE) ? SORT_INIT : acc;
    assign base_prod = (state == ST_IDLE) ? 1'b0 : acc_prod;

    mscn_sort_step u_sort (
        .cur (base),
        .mag (in_msg[MAG_W-1:0]),
        .pos (edge_pos),
        .nxt (step_nxt)
    );

    for (genvar e = 0; e < MAX_EDGES; e++) begin : g_sgn
        assign sgn_nxt[e] = (edge_pos == IDX_W'(e)) ? in_sign : acc_sgn[e];
    end

    mscn_edge_out u_out (
        .res      (res),
        .res_prod (res_prod),
        .res_sgn  (res_sgn),
        .sel_idx  (rd_idx),
        .msg      (rd_msg)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:    if (in_valid && !in_last) state_nxt = ST_COLLECT;
            ST_COLLECT: if (in_valid && in_last)  state_nxt = ST_IDLE;
            default:    state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            acc       <= SORT_INIT;
            acc_prod  <= 1'b0;
            acc_sgn   <= '0;
            res       <= SORT_INIT;
            res_prod  <= 1'b0;
            res_sgn   <= '0;
            row_ready <= 1'b0;
            out_valid <= 1'b0;
            out_msg   <= '0;
        end else begin
            if (in_valid) begin
                acc      <= step_nxt;
                acc_prod <= base_prod ^ in_sign;
                acc_sgn  <= sgn_nxt;
                cnt      <= (edge_pos < IDX_W'(MAX_EDGES - 1)) ? edge_pos + 1'b1 : edge_pos;
                if (in_last) begin
                    res       <= step_nxt;
                    res_prod  <= base_prod ^ in_sign;
                    res_sgn   <= sgn_nxt;
                    row_ready <= 1'b1;
                end
            end
            out_valid <= rd_en && row_ready;
            if (rd_en) out_msg <= rd_msg;
        end
    end
endmodule

// File: rtl/mscn_cell_chk.sv
module mscn_cell_chk
    import mscn_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [5:0] in_msg,
    input logic       in_last,
    input logic       rd_en,
    input logic [4:0] rd_idx,
    input logic       row_ready,
    input logic       out_valid,
    input logic [5:0] out_msg
);
    localparam logic [MAG_W-1:0] NORM_MAX = MAG_MAX - (MAG_MAX >> 2);

    // R9
    resp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(rd_en) && $past(row_ready)));

    // R9
    no_req_no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !out_valid);

    // R6
    norm_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_msg[MAG_W-1:0] <= NORM_MAX));

    // R7
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_ready |=> row_ready);

    // R8
    idle_cycle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !row_ready) |=> !row_ready);
endmodule

bind mscn_cell mscn_cell_chk u_chk (.*);

// File: tb/mscn_cell_tb.sv
`timescale 1ns/100ps
module mscn_cell_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [5:0] in_msg = '0;
    logic       in_last = 1'b0;
    logic       rd_en = 1'b0;
    logic [4:0] rd_idx = '0;
    logic       row_ready;
    logic       out_valid;
    logic [5:0] out_msg;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int  r_mag [24];
    bit  r_sgn [24];
    logic [5:0] exp_msg [24];

    logic [5:0] sb_q [$];
    string      tag_q [$];

    always #2.5 clk = ~clk;

    mscn_cell u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_msg(in_msg),
        .in_last(in_last), .rd_en(rd_en), .rd_idx(rd_idx),
        .row_ready(row_ready), .out_valid(out_valid), .out_msg(out_msg)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Reference from R3..R6: sort with strict less, earliest keeps min, scale 0.75
    task automatic compute_expect(input int n);
        int m1 = 31, m2 = 31, ix = 0;
        bit p = 0;
        for (int i = 0; i < n; i++) begin
            p ^= r_sgn[i];
            if (r_mag[i] < m1) begin m2 = m1; m1 = r_mag[i]; ix = i; end
            else if (r_mag[i] < m2) m2 = r_mag[i];
        end
        for (int i = 0; i < n; i++) begin
            int mm;
            mm = (i == ix) ? m2 : m1;
            mm = mm - (mm >> 2);
            exp_msg[i] = {p ^ r_sgn[i], 5'(mm)};
        end
    endtask

    // Drive edges [first, last_e]; gap inserts idle cycles carrying junk
    task automatic drive_edges(input int first, input int last_e, input bit close, input bit gap);
        for (int i = first; i <= last_e; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_msg   = {r_sgn[i], 5'(r_mag[i])};
            in_last  = close && (i == last_e);
            if (gap) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_msg   = 6'h21;
                in_last  = 1'b1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic read_row(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rd_en  = 1'b1;
            rd_idx = 5'(i);
            sb_q.push_back(exp_msg[i]);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        rd_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Monitor: pops the scoreboard on each response
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R9 unexpected response", out_msg, 0);
            end else begin
                logic [5:0] e;
                string t;
                e = sb_q.pop_front();
                t = tag_q.pop_front();
                check(out_msg === e, t, out_msg, e);
            end
        end
    end

    initial begin
        repeat (40000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check(row_ready == 1'b0, "R1 row_ready", row_ready, 0);
        check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        rst_n = 1'b1;
        // R9: read before any row completes gives no response
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(out_valid == 1'b0, "R9 read before ready", out_valid, 0);

        // Row A: mixed signs, R2 R3 R5 R6
        r_mag[0] = 10; r_mag[1] = 3; r_mag[2] = 20; r_mag[3] = 7;
        r_sgn[0] = 0;  r_sgn[1] = 1; r_sgn[2] = 1;  r_sgn[3] = 0;
        compute_expect(4);
        drive_edges(0, 3, 1, 0);
        check(row_ready == 1'b1, "R7 ready after last", row_ready, 1);
        read_row(4, "R3/R5 mixed row");
        // Explicit values for row A: R2 layout, R6 scaling
        check(exp_msg[1] == 6'h26, "R6 reference edge1", exp_msg[1], 6'h26);

        // Row B: all 31, R3 initial value and R6 top of range
        r_mag[0] = 31; r_mag[1] = 31; r_sgn[0] = 1; r_sgn[1] = 0;
        compute_expect(2);
        drive_edges(0, 1, 1, 0);
        read_row(2, "R6 all-max row");

        // Row C: 24 edges, falling magnitudes, minimum at last position (R4)
        for (int i = 0; i < 24; i++) begin
            r_mag[i] = 30 - i;
            r_sgn[i] = (i % 3 == 0);
        end
        compute_expect(24);
        drive_edges(0, 23, 1, 0);
        read_row(24, "R4 full row");

        // Row D: ties and zero magnitudes, R4 earliest minimum
        r_mag[0] = 0; r_mag[1] = 0; r_mag[2] = 5;
        r_sgn[0] = 1; r_sgn[1] = 1; r_sgn[2] = 1;
        compute_expect(3);
        drive_edges(0, 2, 1, 0);
        read_row(3, "R4 tie zero row");

        // Row E: idle cycles with junk and a stray last flag (R8)
        r_mag[0] = 12; r_mag[1] = 9; r_mag[2] = 15; r_mag[3] = 22; r_mag[4] = 9;
        r_sgn[0] = 0;  r_sgn[1] = 0; r_sgn[2] = 1;  r_sgn[3] = 1;  r_sgn[4] = 1;
        compute_expect(5);
        drive_edges(0, 4, 1, 1);
        read_row(5, "R8 bubbled row");

        // R7: read row E while row F is half collected
        r_mag[0] = 25; r_mag[1] = 18; r_mag[2] = 28; r_mag[3] = 20;
        r_sgn[0] = 1;  r_sgn[1] = 0;  r_sgn[2] = 0;  r_sgn[3] = 0;
        drive_edges(0, 1, 0, 0);
        read_row(5, "R7 held during next row");
        // Row F finished: larger magnitudes than before, R10 no carry-over
        compute_expect(4);
        drive_edges(2, 3, 1, 0);
        read_row(4, "R10 fresh row");

        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R9 all responses arrived", sb_q.size(), 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule